// File: doc/BRIEF.md
# Serial Voltage-ID Command Receiver

This block is the receiving end of a two-wire serial voltage-ID link in a multiphase regulator controller. A fast system clock samples the bus clock pin and the bus data line. Once the controller is in serial mode, the block watches for a start condition and takes in one address byte. If the 7-bit address matches one of three built-in slave addresses and the direction bit is a write, the block acknowledges by pulling the data line low. It then takes in one command byte and acknowledges again. The command's top bit becomes an active-low power-state output. The lower seven bits become the new target VID code, unless they carry the reserved off code, in which case an off flag is raised instead.

Before power-good rises, the block is in boot mode. In boot mode the target code follows the static levels on the two bus pins, read through one of two 2-bit voltage tables, and a strap input chooses the table. On the first rising edge of power-good the current boot code is kept as the starting target and the block moves to serial mode for good. The block never drives the clock pin, so it never stretches the clock.

Top module: `svid_slave`

## Requirements
- R1: While reset is held, the pull output is 0, the update pulse is 0, the off flag is 0, serial mode is 0, the power-state output is 1 and the VID output is 0.
- R2: In boot mode with the strap low, the VID output encodes the pin pair {clock pin, data pin} as follows: 00 gives 1.10 V (code 36), 01 gives 1.00 V (code 44), 10 gives 0.90 V (code 52) and 11 gives 0.80 V (code 60). A code is (1.55 V − voltage) / 12.5 mV.
- R3: In boot mode with the strap high, the same pin pair uses the other table: 00 gives 1.40 V (code 12), 01 gives 1.20 V (code 28), 10 gives 1.00 V (code 44) and 11 gives 0.80 V (code 60).
- R4: A rising edge of power-good sets serial mode and keeps the boot code it sees at that moment. Serial mode then stays set, including after power-good falls. In boot mode the block never pulls the data line.
- R5: A start condition is the data line falling while the clock pin is high. After a start, eight bits are sampled on clock rising edges, MSB first: a 7-bit address and then a direction bit (0 = write). When the address matches one of the three addresses and the direction is write, the block pulls the data line low from the next clock fall until the fall after the ninth rise.
- R6: On an address mismatch or a read direction bit, no acknowledge is driven and the rest of the transfer leaves every output unchanged.
- R7: After the address acknowledge, eight data bits are sampled MSB first, and a second acknowledge is driven over the following clock pulse in the same way.
- R8: The power-state output takes command bit 7 on every accepted command: 1 leaves it high and 0 drives it low.
- R9: Command bits 6:0 load the VID output. Each accepted command gives exactly one update pulse of one clock cycle. The outputs change three system clocks after the bus pin edge that completes the byte.
- R10: A command whose bits 6:0 equal the off code sets the off flag and leaves the VID output unchanged. The next command with any other code clears the flag.
- R11: A stop condition (data rising while the clock pin is high) or a new start at any point ends the transfer in progress with no update. A transfer that follows works normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, much faster than the bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_clk_i | input | 1 | Bus clock pin, input only |
| bus_dat_i | input | 1 | Bus data line as seen on the wire |
| bus_dat_pull_o | output | 1 | 1 pulls the data line low (open-drain acknowledge) |
| pwr_good_i | input | 1 | Power-good; its first rising edge leaves boot mode |
| fixed_sel_i | input | 1 | Strap that selects the fixed-mode table in boot mode |
| serial_mode_o | output | 1 | 1 once serial mode is entered |
| vid_code_o | output | 7 | Current target VID code |
| pstate_n_o | output | 1 | Active-low power-state indicator |
| vid_off_o | output | 1 | 1 after an off command |
| vid_upd_o | output | 1 | One-cycle pulse for each accepted command |

## Verification
The bench builds the block with three slave addresses, 0x21, 0x42 and 0x13, which differ from each other in several bits, and with the off code set to 0x55. This way a swapped comparison slot or a wrong off value changes the acknowledge or the target. The bus runs at one sixteenth of the system clock. This gives the two-flop synchronizer and the edge detectors room between pin edges, so the reference model can predict every output exactly two sampled edges after the pin it reacts to. Each address is used, a read with a valid address is sent, transfers are cut off by a stop and by a repeated start, and the power-good edge is taken with a pin pair other than the reset value.

// File: rtl/svid_pkg.sv
`timescale 1ns/1ps
package svid_pkg;
  localparam int SVID_BYTE_W = 8;
  localparam int SVID_CODE_W = 7;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_AHOLD, ST_AACK, ST_AREL,
    ST_DATA, ST_DHOLD, ST_DACK, ST_DREL
  } svid_st_e;

  // boot table: 1.1 V down to 0.8 V in 100 mV steps, 12.5 mV per code
  function automatic logic [SVID_CODE_W-1:0] boot_code(input logic [1:0] pins);
    return SVID_CODE_W'(36) + SVID_CODE_W'({pins, 3'b000});
  endfunction

  // fixed table: 1.4 V down to 0.8 V in 200 mV steps
  function automatic logic [SVID_CODE_W-1:0] fixed_code(input logic [1:0] pins);
    return SVID_CODE_W'(12) + SVID_CODE_W'({pins, 4'b0000});
  endfunction

  function automatic logic addr_match(input logic [SVID_BYTE_W-1:0] b,
                                      input logic [6:0] a0,
                                      input logic [6:0] a1,
                                      input logic [6:0] a2);
    logic hit;
    hit = (b[7:1] == a0) || (b[7:1] == a1) || (b[7:1] == a2);
    return hit && !b[0];
  endfunction
endpackage

// File: rtl/svid_sync.sv
`timescale 1ns/1ps
module svid_sync #(
  parameter int           W       = 4,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain <= {STAGES{RST_VAL[g]}};
      else         chain <= {chain[STAGES-2:0], d_i[g]};
    end
    assign q_o[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/svid_proto.sv
`timescale 1ns/1ps
module svid_proto
  import svid_pkg::*;
#(
  parameter logic [6:0] ADDR0 = 7'h58,
  parameter logic [6:0] ADDR1 = 7'h59,
  parameter logic [6:0] ADDR2 = 7'h5C
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   en_i,
  input  logic                   scl_i,
  input  logic                   sda_i,
  output logic                   pull_o,
  output logic                   start_o,
  output logic                   stop_o,
  output logic                   byte_stb_o,
  output logic [SVID_BYTE_W-1:0] byte_o
);
  localparam int CW = $clog2(SVID_BYTE_W + 1);

  svid_st_e               st;
  logic                   scl_q, sda_q;
  logic [CW-1:0]          cnt;
  logic [SVID_BYTE_W-1:0] shreg;
  logic                   rise, fall, last;
  logic [SVID_BYTE_W-1:0] nxt_byte;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign start_o  = en_i & scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o   = en_i & scl_i & scl_q & ~sda_q & sda_i;
  assign rise     = scl_i & ~scl_q;
  assign fall     = ~scl_i & scl_q;
  assign nxt_byte = {shreg[SVID_BYTE_W-2:0], sda_i};
  assign last     = (cnt == CW'(SVID_BYTE_W - 1));

  assign byte_stb_o = en_i & (st == ST_DATA) & rise & last;
  assign byte_o     = nxt_byte;
  assign pull_o     = (st == ST_AACK) || (st == ST_AREL) ||
                      (st == ST_DACK) || (st == ST_DREL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st    <= ST_IDLE;
      cnt   <= '0;
      shreg <= '0;
    end else if (!en_i) begin
      st <= ST_IDLE;
    end else if (start_o) begin
      st  <= ST_ADDR;
      cnt <= '0;
    end else if (stop_o) begin
      st <= ST_IDLE;
    end else begin
      unique case (st)
        ST_ADDR, ST_DATA: if (rise) begin
          shreg <= nxt_byte;
          cnt   <= cnt + 1'b1;
          if (last) begin
            if (st == ST_DATA) st <= ST_DHOLD;
            else if (addr_match(nxt_byte, ADDR0, ADDR1, ADDR2)) st <= ST_AHOLD;
            else st <= ST_IDLE;
          end
        end
        ST_AHOLD: if (fall) st <= ST_AACK;
        ST_AACK:  if (rise) st <= ST_AREL;
        ST_AREL:  if (fall) begin
          st  <= ST_DATA;
          cnt <= '0;
        end
        ST_DHOLD: if (fall) st <= ST_DACK;
        ST_DACK:  if (rise) st <= ST_DREL;
        ST_DREL:  if (fall) st <= ST_IDLE;
        default:  st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/svid_target.sv
`timescale 1ns/1ps
module svid_target
  import svid_pkg::*;
#(
  parameter logic [SVID_CODE_W-1:0] OFF_CODE = 7'h7C
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   pg_i,
  input  logic                   fixed_i,
  input  logic [1:0]             pins_i,
  input  logic                   cmd_stb_i,
  input  logic [SVID_BYTE_W-1:0] cmd_i,
  output logic                   serial_o,
  output logic [SVID_CODE_W-1:0] vid_o,
  output logic                   pstate_n_o,
  output logic                   off_o,
  output logic                   upd_o
);
  logic                   pg_q, pg_rise;
  logic [SVID_CODE_W-1:0] strap_code;

  assign pg_rise    = pg_i & ~pg_q;
  assign strap_code = fixed_i ? fixed_code(pins_i) : boot_code(pins_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pg_q       <= 1'b0;
      serial_o   <= 1'b0;
      vid_o      <= '0;
      pstate_n_o <= 1'b1;
      off_o      <= 1'b0;
      upd_o      <= 1'b0;
    end else begin
      pg_q  <= pg_i;
      upd_o <= 1'b0;
      if (!serial_o) begin
        vid_o <= strap_code;
        if (pg_rise) serial_o <= 1'b1;
      end else if (cmd_stb_i) begin
        upd_o      <= 1'b1;
        pstate_n_o <= cmd_i[SVID_BYTE_W-1];
        if (cmd_i[SVID_CODE_W-1:0] == OFF_CODE) begin
          off_o <= 1'b1;
        end else begin
          off_o <= 1'b0;
          vid_o <= cmd_i[SVID_CODE_W-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/svid_slave.sv
`timescale 1ns/1ps
module svid_slave
  import svid_pkg::*;
#(
  parameter logic [6:0] ADDR0       = 7'h58,
  parameter logic [6:0] ADDR1       = 7'h59,
  parameter logic [6:0] ADDR2       = 7'h5C,
  parameter logic [6:0] OFF_CODE    = 7'h7C,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bus_clk_i,
  input  logic       bus_dat_i,
  output logic       bus_dat_pull_o,
  input  logic       pwr_good_i,
  input  logic       fixed_sel_i,
  output logic       serial_mode_o,
  output logic [6:0] vid_code_o,
  output logic       pstate_n_o,
  output logic       vid_off_o,
  output logic       vid_upd_o
);
  localparam int SYN_W = 4;

  logic [SYN_W-1:0]       syn;
  logic                   start_det, stop_det, byte_stb;
  logic [SVID_BYTE_W-1:0] cmd_byte;

  svid_sync #(.W(SYN_W), .STAGES(SYNC_STAGES), .RST_VAL(4'b1100)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({bus_clk_i, bus_dat_i, pwr_good_i, fixed_sel_i}),
    .q_o   (syn)
  );

  svid_proto #(.ADDR0(ADDR0), .ADDR1(ADDR1), .ADDR2(ADDR2)) u_proto (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (serial_mode_o),
    .scl_i     (syn[3]),
    .sda_i     (syn[2]),
    .pull_o    (bus_dat_pull_o),
    .start_o   (start_det),
    .stop_o    (stop_det),
    .byte_stb_o(byte_stb),
    .byte_o    (cmd_byte)
  );

  svid_target #(.OFF_CODE(OFF_CODE)) u_target (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pg_i      (syn[1]),
    .fixed_i   (syn[0]),
    .pins_i    (syn[3:2]),
    .cmd_stb_i (byte_stb),
    .cmd_i     (cmd_byte),
    .serial_o  (serial_mode_o),
    .vid_o     (vid_code_o),
    .pstate_n_o(pstate_n_o),
    .off_o     (vid_off_o),
    .upd_o     (vid_upd_o)
  );
endmodule

// File: rtl/svid_slave_chk.sv
`timescale 1ns/1ps
module svid_slave_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       serial,
  input logic       pull,
  input logic       upd,
  input logic       off,
  input logic [6:0] vid,
  input logic       stop_det,
  input logic       byte_stb
);
  assert_serial_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    serial |=> serial);
  assert_no_pull_in_boot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !serial |-> !pull);
  assert_upd_one_cycle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd |=> !upd);
  assert_vid_moves_with_upd_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(serial) && !$stable(vid)) |-> upd);
  assert_byte_gives_upd_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_stb |=> upd);
  assert_off_holds_vid_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd && off) |-> $stable(vid));
  assert_stop_releases_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> !pull);
endmodule

bind svid_slave svid_slave_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .serial  (serial_mode_o),
  .pull    (bus_dat_pull_o),
  .upd     (vid_upd_o),
  .off     (vid_off_o),
  .vid     (vid_code_o),
  .stop_det(stop_det),
  .byte_stb(byte_stb)
);

// File: tb/svid_slave_bench.sv
`timescale 1ns/1ps
module svid_slave_bench;
  localparam logic [6:0] A0 = 7'h21, A1 = 7'h42, A2 = 7'h13, OFFC = 7'h55;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda_drv = 1'b1, pg = 1'b0, fx = 1'b0;
  logic pull, serial, pstn, off, upd;
  logic [6:0] vid;
  wire  sda_line = sda_drv & ~pull;

  always #2 clk = ~clk;

  svid_slave #(.ADDR0(A0), .ADDR1(A1), .ADDR2(A2), .OFF_CODE(OFFC)) u_svid_slave (
    .clk_i(clk), .rst_ni(rst_n), .bus_clk_i(scl), .bus_dat_i(sda_line),
    .bus_dat_pull_o(pull), .pwr_good_i(pg), .fixed_sel_i(fx),
    .serial_mode_o(serial), .vid_code_o(vid), .pstate_n_o(pstn),
    .vid_off_o(off), .vid_upd_o(upd)
  );

  int checks = 0, failures = 0, upd_seen = 0, upd_exp = 0;
  bit done = 0, cmp_en = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int to_code(input int mv);
    return ((1550 - mv) * 2) / 25;
  endfunction
  function automatic int strap_expect(input bit c, input bit d, input bit f);
    int idx = c * 2 + d;
    return f ? to_code(1400 - 200 * idx) : to_code(1100 - 100 * idx);
  endfunction
  function automatic bit my_addr(input int b);
    int a = b / 2;
    return (b % 2 == 0) && (a == A0 || a == A1 || a == A2);
  endfunction

  // ---------------- behavioural reference model ----------------
  logic [3:0] smp = 4'b1100;
  always @(negedge clk) begin
    #1 smp = {scl, sda_line, pg, fx};
  end

  bit m_ser, m_act, m_drive, m_upd, m_off, m_ps;
  int m_vid, m_nr, m_acc, m_dat;
  bit psc, psd, ppg;
  logic [11:0] e_cur, e_1, e_2;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ser = 0; m_act = 0; m_drive = 0; m_upd = 0; m_off = 0; m_ps = 1;
      m_vid = 0; psc = 1; psd = 1; ppg = 0;
    end else begin
      bit sc, sd;
      sc = smp[3]; sd = smp[2];
      m_upd = 0;
      if (!m_ser) begin
        m_act = 0; m_drive = 0;
      end else if (psc && sc && psd && !sd) begin
        m_act = 1; m_nr = 0; m_acc = 0; m_dat = 0; m_drive = 0;
      end else if (psc && sc && !psd && sd) begin
        m_act = 0; m_drive = 0;
      end else if (m_act && !psc && sc) begin
        m_nr++;
        if (m_nr <= 8) begin
          m_acc = m_acc * 2 + sd;
          if (m_nr == 8 && !my_addr(m_acc)) m_act = 0;
        end else if (m_nr >= 10 && m_nr <= 17) begin
          m_dat = m_dat * 2 + sd;
          if (m_nr == 17) begin
            m_upd = 1; m_ps = (m_dat >= 128);
            if (m_dat % 128 == OFFC) m_off = 1;
            else begin m_off = 0; m_vid = m_dat % 128; end
          end
        end
      end else if (m_act && psc && !sc) begin
        if (m_nr == 8 || m_nr == 17) m_drive = 1;
        else if (m_nr == 9) m_drive = 0;
        else if (m_nr == 18) begin m_drive = 0; m_act = 0; end
      end
      if (!m_ser) begin
        m_vid = strap_expect(sc, sd, smp[0]);
        if (smp[1] && !ppg) m_ser = 1;
      end
      psc = sc; psd = sd; ppg = smp[1];
    end
    e_2 = e_1; e_1 = e_cur;
    e_cur = {m_drive, m_upd, m_off, m_ps, m_ser, 7'(m_vid)};
  end

  always @(negedge clk) begin
    if (cmp_en && !done) begin
      chk(pull == e_2[11], "R5 R7 pull", pull, e_2[11]);
      chk(upd == e_2[10], "R9 upd", upd, e_2[10]);
      chk(off == e_2[9], "R10 off", off, e_2[9]);
      chk(pstn == e_2[8], "R8 pstate", pstn, e_2[8]);
      chk(serial == e_2[7], "R4 serial", serial, e_2[7]);
      chk(vid == e_2[6:0], "R2 R3 R9 vid", vid, e_2[6:0]);
    end
    if (upd) upd_seen++;
  end

  // ---------------- bus driver tasks ----------------
  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
    #0.5;
  endtask
  task automatic bus_start();
    scl = 1; sda_drv = 1; waitc(8);
    sda_drv = 0; waitc(8);
    scl = 0; waitc(4);
  endtask
  task automatic bus_bit(input bit b, output bit seen);
    sda_drv = b; waitc(4);
    scl = 1; waitc(4);
    seen = sda_line; waitc(4);
    scl = 0; waitc(4);
  endtask
  task automatic bus_stop();
    sda_drv = 0; waitc(4);
    scl = 1; waitc(8);
    sda_drv = 1; waitc(8);
  endtask
  task automatic xfer(input logic [6:0] a, input bit rd, input logic [7:0] d,
                      output bit ack1, output bit ack2);
    bit s;
    bus_start();
    for (int i = 6; i >= 0; i--) bus_bit(a[i], s);
    bus_bit(rd, s);
    bus_bit(1'b1, s); ack1 = !s;
    for (int i = 7; i >= 0; i--) bus_bit(d[i], s);
    bus_bit(1'b1, s); ack2 = !s;
    bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    bit k1, k2, s;
    waitc(5);
    chk(!pull && !upd && !off && !serial, "R1 reset flags", {pull, upd, off, serial}, 0);
    chk(pstn == 1, "R1 reset pstate", pstn, 1);
    chk(vid == 0, "R1 reset vid", vid, 0);
    rst_n = 1;
    waitc(4); cmp_en = 1;

    for (int p = 0; p < 4; p++) begin
      scl = p[1]; sda_drv = p[0]; waitc(6);
      chk(vid == strap_expect(p[1], p[0], 0), "R2 boot table", vid, strap_expect(p[1], p[0], 0));
    end
    fx = 1;
    for (int p = 0; p < 4; p++) begin
      scl = p[1]; sda_drv = p[0]; waitc(6);
      chk(vid == 12 + 16 * p, "R3 fixed table", vid, 12 + 16 * p);
    end
    fx = 0; scl = 1; sda_drv = 1; waitc(6);

    xfer(A0, 0, 8'h90, k1, k2);
    chk(!k1 && !k2, "R4 no ack in boot", k1, 0);

    scl = 1; sda_drv = 0; waitc(6);
    pg = 1; waitc(6);
    chk(serial == 1, "R4 serial entered", serial, 1);
    chk(vid == 52, "R4 boot code kept", vid, 52);
    sda_drv = 1; waitc(6);
    chk(vid == 52, "R4 pins ignored after pg", vid, 52);

    xfer(A1, 0, 8'hA0, k1, k2); upd_exp++;
    chk(k1, "R5 address ack", k1, 1);
    chk(k2, "R7 data ack", k2, 1);
    chk(vid == 7'h20 && pstn == 1, "R8 R9 command A1", vid, 7'h20);

    xfer(A2, 0, 8'h15, k1, k2); upd_exp++;
    chk(vid == 7'h15, "R9 command A2", vid, 7'h15);
    chk(pstn == 0, "R8 power state low", pstn, 0);

    xfer(A0, 0, 8'h8A, k1, k2); upd_exp++;
    chk(k1 && vid == 7'h0A && pstn == 1, "R5 command A0", vid, 7'h0A);

    xfer(7'h22, 0, 8'h33, k1, k2);
    chk(!k1 && !k2, "R6 mismatch no ack", k1, 0);
    chk(vid == 7'h0A, "R6 mismatch ignored", vid, 7'h0A);
    xfer(A1, 1, 8'h33, k1, k2);
    chk(!k1 && vid == 7'h0A, "R6 read ignored", vid, 7'h0A);

    xfer(A1, 0, {1'b0, OFFC}, k1, k2); upd_exp++;
    chk(off == 1, "R10 off set", off, 1);
    chk(vid == 7'h0A, "R10 vid held", vid, 7'h0A);
    xfer(A1, 0, 8'h81, k1, k2); upd_exp++;
    chk(off == 0 && vid == 1, "R10 off cleared", vid, 1);

    bus_start();
    for (int i = 6; i >= 0; i--) bus_bit(A2[i], s);
    bus_bit(0, s); bus_bit(1, s);
    for (int i = 0; i < 4; i++) bus_bit(0, s);
    bus_stop();
    chk(vid == 1 && off == 0, "R11 stop aborts", vid, 1);

    bus_start();
    for (int i = 6; i >= 0; i--) bus_bit(A0[i], s);
    bus_bit(0, s); bus_bit(1, s);
    for (int i = 0; i < 3; i++) bus_bit(1, s);
    scl = 0; sda_drv = 1; waitc(4);
    xfer(A0, 0, 8'h7E, k1, k2); upd_exp++;
    chk(k1 && k2 && vid == 7'h7E, "R11 repeated start then transfer", vid, 7'h7E);

    pg = 0; waitc(8);
    chk(serial == 1, "R4 pg fall keeps serial", serial, 1);
    waitc(8);
    chk(upd_seen == upd_exp, "R9 update pulse count", upd_seen, upd_exp);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule